// File: doc/BRIEF.md
# Stepped-Clock RAM Boot Sequencer

This block loads a memory image into the RAM of a small CPU system that has no boot ROM. It takes over the CPU clock and the open-drain reset line, walks the CPU through its reset, and then single-steps it. On each step it latches one byte into the glue logic's byte buffer. While load mode is active, every CPU read is answered from that buffer and every CPU write goes to RAM. The CPU therefore fetches nothing real from memory: the sequencer injects every vector, opcode and operand byte. For each image byte it feeds a short loop of four instructions: a jump target, a load-immediate that carries the image byte, a store-absolute-long to the destination, and a jump back.

The destination address starts at a given 16-bit value and increases by one for each image byte. The bank byte of each store depends on the destination page. When the address wraps past 0xFFFF, the sequencer leaves load mode, asserts reset again and enables the free-running clock. It then holds reset for a fixed window before it releases reset, so the CPU restarts from the freshly loaded image.

The image source is a synchronous read port with one cycle of latency, addressed by an offset that counts from zero. `cpu_clk` is the stepped clock. An outer multiplexer selects the free-running clock whenever `free_clk_en` is high.

Top module: `boot_seq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `cpu_clk`, `cpu_res_drive`, `load_mode`, `buf_load`, `busy` and `done` are 0, and `free_clk_en` is 1.
- R2: A `start` pulse in idle drops `free_clk_en` and raises `busy` in the next cycle. `cpu_res_drive` rises one cycle after that, so the free clock is already stopped when reset is driven. A `start` pulse while `busy` is high has no effect.
- R3: Each stepped clock beat is LO_CYC cycles low followed by HI_CYC cycles high. Reset is driven through RST_BEATS complete beats.
- R4: In the beat after those RST_BEATS beats, reset is released and `load_mode` is set in the same cycle that `cpu_clk` rises. `load_mode` is never high while reset is driven.
- R5: After the release beat, one detect beat and IDLE_BEATS (default 6) idle beats pass with no byte latched before the first injected byte.
- R6: Exactly one byte is injected per beat. `buf_data` changes and `buf_load` pulses for one cycle in the first low cycle of the beat, before `cpu_clk` rises.
- R7: For each image byte, the ten injected bytes in order are 0x00, 0x03, the load-immediate opcode (default 0xA9), the image byte, the store-absolute-long opcode (default 0x8F), the destination low byte, the destination high byte, the bank byte, 0xFF, and the jump opcode (default 0x4C).
- R8: The bank byte is 0x00 when the destination high byte is below SPLIT_HI (default 0xD0), and 0x04 otherwise.
- R9: The image byte for the n-th copied address is the data read at image offset n (n counting from 0). The destination address increases by one after each ten-byte group.
- R10: After the group for destination 0xFFFF, `load_mode` clears while `cpu_res_drive` and `free_clk_en` rise, all in one cycle. Reset stays driven for FIN_HOLD cycles with `cpu_clk` low. It is then released in the same cycle that `done` pulses for one cycle and `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a load |
| start_addr | input | 16 | First destination address in CPU space |
| img_addr | output | 16 | Offset into the image source |
| img_data | input | 8 | Image byte, valid one cycle after `img_addr` |
| cpu_clk | output | 1 | Stepped CPU clock |
| cpu_res_drive | output | 1 | 1 pulls the open-drain reset line low |
| load_mode | output | 1 | Load-mode bit for the glue decoder |
| free_clk_en | output | 1 | Selects the free-running CPU clock |
| buf_data | output | 8 | Byte presented to the glue byte buffer |
| buf_load | output | 1 | One-cycle latch strobe for `buf_data` |
| busy | output | 1 | Load sequence in progress |
| done | output | 1 | One-cycle pulse when reset is released at the end |

## Verification
On every cycle, the embedded assertions check the interlocks between outputs. A byte is latched only while the stepped clock is low. Load mode never coincides with driven reset. The stepped clock stays low whenever the free clock is enabled. Reset is never already driven when the free clock stops, and `done` is a single-cycle pulse. What only the bench scenarios can show is the timing and content: the number of reset, detect and idle beats, the exact ten-byte stream with the bank switch across the page threshold, the image offset order, the wrap at 0xFFFF, and a `start` pulse ignored in the middle of a load. A behavioural reference model builds the whole expected trace and compares it cycle by cycle.

// File: rtl/boot_seq_pkg.sv
// Shared types for the stepped-clock boot sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package boot_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // free clock selected, waiting for start
        ST_HALT,   // free clock just stopped, reset not yet driven
        ST_RESET,  // reset driven while stepping
        ST_WAKE,   // detect beat plus idle beats
        ST_FEED,   // injecting the per-address byte loop
        ST_FIN     // reset driven under the free clock
    } seq_state_t;

    localparam int GROUP_LEN = 10;  // bytes injected per image byte

endpackage

// File: rtl/boot_beat_timer.sv
// Generates the stepped CPU clock as beats: LO_CYC cycles low, then HI_CYC
// cycles high. Flags the cycle before the rise and the last high cycle.
// Assumes: LO_CYC >= 2 and HI_CYC >= 1. The counter restarts low whenever run drops.
module boot_beat_timer #(
    parameter int LO_CYC = 4,
    parameter int HI_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_hi,
    output logic at_rise,
    output logic at_end
);
    localparam int MAXC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic          hi;

    // Advance the phase counter and toggle the clock level at phase ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            hi  <= 1'b0;
        end else if (!hi) begin
            if (cnt == CW'(LO_CYC - 1)) begin
                cnt <= '0;
                hi  <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (cnt == CW'(HI_CYC - 1)) begin
                cnt <= '0;
                hi  <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Decode the phase boundary flags for the controller.
    always_comb begin
        phase_hi = hi;
        at_rise  = run && !hi && (cnt == CW'(LO_CYC - 1));
        at_end   = run &&  hi && (cnt == CW'(HI_CYC - 1));
    end

    // R3: the clock can only fall when no run is active or a high phase completes
    a_r3_fall_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (hi && run && !at_end) |=> hi);

endmodule

// File: rtl/boot_byte_gen.sv
// Selects the byte to inject for a position in the ten-byte loop.
// Assumes: idx below 10; img_byte already valid for the current offset.
module boot_byte_gen #(
    parameter logic [7:0] OP_LDI   = 8'hA9,
    parameter logic [7:0] OP_STL   = 8'h8F,
    parameter logic [7:0] OP_JMP   = 8'h4C,
    parameter logic [7:0] SPLIT_HI = 8'hD0
) (
    input  logic [3:0]  idx,
    input  logic [7:0]  img_byte,
    input  logic [15:0] dest,
    output logic [7:0]  byte_out
);
    localparam logic [7:0] TGT_LO  = 8'h00;
    localparam logic [7:0] TGT_HI  = 8'h03;
    localparam logic [7:0] BANK_LO = 8'h00;
    localparam logic [7:0] BANK_HI = 8'h04;
    localparam logic [7:0] FILLER  = 8'hFF;

    // Map the loop position to its byte value.
    always_comb begin
        unique case (idx)
            4'd0:    byte_out = TGT_LO;
            4'd1:    byte_out = TGT_HI;
            4'd2:    byte_out = OP_LDI;
            4'd3:    byte_out = img_byte;
            4'd4:    byte_out = OP_STL;
            4'd5:    byte_out = dest[7:0];
            4'd6:    byte_out = dest[15:8];
            4'd7:    byte_out = (dest[15:8] < SPLIT_HI) ? BANK_LO : BANK_HI;
            4'd8:    byte_out = FILLER;
            default: byte_out = OP_JMP;
        endcase
    end

    // R7: the loop index never leaves the ten-byte group
    always_comb begin
        a_r7_idx_range: assert (idx < 4'd10 || $isunknown(idx));
    end

endmodule

// File: rtl/boot_seq_ctrl.sv
// Boot sequencer top: stops the free clock, steps the CPU through reset,
// injects the copy loop one byte per beat, then hands over with a reset.
// Assumes: start_addr is stable in the start cycle; the image port has one
// cycle of read latency; FIN_HOLD >= 1 and RST_BEATS >= 2.
module boot_seq_ctrl
    import boot_seq_pkg::*;
#(
    parameter int         LO_CYC     = 4,
    parameter int         HI_CYC     = 4,
    parameter int         RST_BEATS  = 2,
    parameter int         IDLE_BEATS = 6,
    parameter int         FIN_HOLD   = 8,
    parameter logic [7:0] OP_LDI     = 8'hA9,
    parameter logic [7:0] OP_STL     = 8'h8F,
    parameter logic [7:0] OP_JMP     = 8'h4C,
    parameter logic [7:0] SPLIT_HI   = 8'hD0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] start_addr,
    output logic [15:0] img_addr,
    input  logic [7:0]  img_data,
    output logic        cpu_clk,
    output logic        cpu_res_drive,
    output logic        load_mode,
    output logic        free_clk_en,
    output logic [7:0]  buf_data,
    output logic        buf_load,
    output logic        busy,
    output logic        done
);
    localparam int MAXB1 = (RST_BEATS > IDLE_BEATS) ? RST_BEATS : IDLE_BEATS;
    localparam int MAXB  = (MAXB1 > FIN_HOLD) ? MAXB1 : FIN_HOLD;
    localparam int BW    = $clog2(MAXB + 1);
    localparam logic [3:0] LAST_IDX = 4'(GROUP_LEN - 1);

    seq_state_t    state;
    logic [BW-1:0] beat;
    logic [3:0]    idx;
    logic [3:0]    nidx;
    logic [15:0]   dest;
    logic [15:0]   src;
    logic          run;
    logic          phase_hi;
    logic          at_rise;
    logic          at_end;
    logic [7:0]    next_byte;

    // Stepping runs only in the reset, wake and feed stretches.
    always_comb begin
        run  = (state == ST_RESET) || (state == ST_WAKE) || (state == ST_FEED);
        nidx = (state == ST_FEED && idx != LAST_IDX) ? idx + 4'd1 : 4'd0;
    end

    boot_beat_timer #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .phase_hi (phase_hi),
        .at_rise  (at_rise),
        .at_end   (at_end)
    );

    boot_byte_gen #(
        .OP_LDI(OP_LDI), .OP_STL(OP_STL), .OP_JMP(OP_JMP), .SPLIT_HI(SPLIT_HI)
    ) u_bytes (
        .idx      (nidx),
        .img_byte (img_data),
        .dest     (dest),
        .byte_out (next_byte)
    );

    // Sequence control: reset handshake, byte injection and hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            beat          <= '0;
            idx           <= '0;
            dest          <= '0;
            src           <= '0;
            cpu_res_drive <= 1'b0;
            load_mode     <= 1'b0;
            free_clk_en   <= 1'b1;
            buf_data      <= '0;
            buf_load      <= 1'b0;
            busy          <= 1'b0;
            done          <= 1'b0;
        end else begin
            buf_load <= 1'b0;
            done     <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        free_clk_en <= 1'b0;
                        busy        <= 1'b1;
                        dest        <= start_addr;
                        src         <= '0;
                        state       <= ST_HALT;
                    end
                end
                ST_HALT: begin
                    cpu_res_drive <= 1'b1;
                    beat          <= '0;
                    state         <= ST_RESET;
                end
                ST_RESET: begin
                    if (at_rise && beat == BW'(RST_BEATS)) begin
                        cpu_res_drive <= 1'b0;
                        load_mode     <= 1'b1;
                    end
                    if (at_end) begin
                        if (beat == BW'(RST_BEATS)) begin
                            beat  <= '0;
                            state <= ST_WAKE;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                ST_WAKE: begin
                    if (at_end) begin
                        if (beat == BW'(IDLE_BEATS)) begin
                            idx      <= '0;
                            buf_data <= next_byte;
                            buf_load <= 1'b1;
                            state    <= ST_FEED;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                ST_FEED: begin
                    if (at_end) begin
                        if (idx == LAST_IDX && dest == 16'hFFFF) begin
                            load_mode     <= 1'b0;
                            cpu_res_drive <= 1'b1;
                            free_clk_en   <= 1'b1;
                            beat          <= '0;
                            state         <= ST_FIN;
                        end else begin
                            if (idx == LAST_IDX) begin
                                dest <= dest + 16'd1;
                                src  <= src + 16'd1;
                            end
                            idx      <= nidx;
                            buf_data <= next_byte;
                            buf_load <= 1'b1;
                        end
                    end
                end
                ST_FIN: begin
                    if (beat == BW'(FIN_HOLD - 1)) begin
                        cpu_res_drive <= 1'b0;
                        done          <= 1'b1;
                        busy          <= 1'b0;
                        state         <= ST_IDLE;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the outward clock and the image offset.
    always_comb begin
        cpu_clk  = phase_hi;
        img_addr = src;
    end

    // R6: a byte is only latched while the stepped clock is low
    a_r6_latch_low: assert property (@(posedge clk) disable iff (!rst_n)
        buf_load |-> !cpu_clk);
    // R4: load mode and driven reset never overlap
    a_r4_no_lm_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        load_mode |-> !cpu_res_drive);
    // R10: stepped clock stays low while the free clock is selected
    a_r10_free_clk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        free_clk_en |-> !cpu_clk);
    // R2: the free clock stops before reset is driven
    a_r2_halt_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(free_clk_en) |-> !cpu_res_drive);
    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/boot_seq_ctrl_tb_top.sv
// Bench: builds the full expected per-cycle trace behaviourally in a queue
// and compares every output on every cycle at the falling edge.
module boot_seq_ctrl_tb_top;

    localparam int LO = 2;
    localparam int HI = 2;
    localparam int RB = 2;
    localparam int IB = 6;
    localparam int FH = 4;
    localparam logic [7:0] SPLIT = 8'hFF;

    typedef struct {
        logic       ck;
        logic       rs;
        logic       lm;
        logic       fr;
        logic       by;
        logic       dn;
        logic       ld;
        logic [7:0] bd;
        string      tag;
        string      btag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_addr = '0;
    logic [15:0] img_addr;
    logic [7:0]  img_data = '0;
    logic        cpu_clk, cpu_res_drive, load_mode, free_clk_en;
    logic [7:0]  buf_data;
    logic        buf_load, busy, done;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    function automatic logic [7:0] img_fn(input logic [15:0] a);
        return (a[7:0] * 8'd37 + 8'd11) ^ a[15:8];
    endfunction

    // Synchronous image source with one cycle of latency.
    always @(posedge clk) img_data <= img_fn(img_addr);

    boot_seq_ctrl #(
        .LO_CYC(LO), .HI_CYC(HI), .RST_BEATS(RB), .IDLE_BEATS(IB),
        .FIN_HOLD(FH), .SPLIT_HI(SPLIT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .img_addr(img_addr), .img_data(img_data), .cpu_clk(cpu_clk),
        .cpu_res_drive(cpu_res_drive), .load_mode(load_mode),
        .free_clk_en(free_clk_en), .buf_data(buf_data), .buf_load(buf_load),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int n, input logic ck, input logic rs, input logic lm,
                        input logic fr, input logic by, input logic dn,
                        input logic ld, input logic [7:0] bd,
                        input string tag, input string btag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.ck = ck; e.rs = rs; e.lm = lm; e.fr = fr; e.by = by; e.dn = dn;
            e.ld = (i == 0) ? ld : 1'b0; e.bd = bd; e.tag = tag; e.btag = btag;
            q.push_back(e);
        end
    endtask

    // Reference model: whole load sequence for one start address.
    task automatic build(input logic [15:0] a0);
        logic [15:0] d;
        int n;
        push(1, 0, 0, 0, 0, 1, 0, 0, 8'h00, "R2", "");
        for (int b = 0; b <= RB; b++) begin
            push(LO, 0, 1, 0, 0, 1, 0, 0, 8'h00, "R3", "");
            if (b == RB) push(HI, 1, 0, 1, 0, 1, 0, 0, 8'h00, "R4", "");
            else         push(HI, 1, 1, 0, 0, 1, 0, 0, 8'h00, "R3", "");
        end
        for (int b = 0; b <= IB; b++) begin
            push(LO, 0, 0, 1, 0, 1, 0, 0, 8'h00, "R5", "");
            push(HI, 1, 0, 1, 0, 1, 0, 0, 8'h00, "R5", "");
        end
        d = a0;
        n = 0;
        forever begin
            for (int k = 0; k < 10; k++) begin
                logic [7:0] v;
                string bt;
                bt = "R7";
                case (k)
                    0: v = 8'h00;
                    1: v = 8'h03;
                    2: v = 8'hA9;
                    3: begin v = img_fn(16'(n)); bt = "R9"; end
                    4: v = 8'h8F;
                    5: begin v = d[7:0];  bt = "R9"; end
                    6: begin v = d[15:8]; bt = "R9"; end
                    7: begin v = (d[15:8] < SPLIT) ? 8'h00 : 8'h04; bt = "R8"; end
                    8: v = 8'hFF;
                    default: v = 8'h4C;
                endcase
                push(1, 0, 0, 1, 0, 1, 0, 1, v, "R6", bt);
                push(LO - 1, 0, 0, 1, 0, 1, 0, 0, v, "R6", bt);
                push(HI, 1, 0, 1, 0, 1, 0, 0, v, "R6", bt);
            end
            if (d == 16'hFFFF) break;
            d = d + 16'd1;
            n++;
        end
        push(FH, 0, 1, 0, 1, 1, 0, 0, 8'h00, "R10", "");
        push(1, 0, 0, 0, 1, 0, 1, 0, 8'h00, "R10", "");
        push(2, 0, 0, 0, 1, 0, 0, 0, 8'h00, "R10", "");
    endtask

    task automatic compare_one(input exp_t e);
        chk(cpu_clk == e.ck, e.tag, "cpu_clk", int'(cpu_clk), int'(e.ck));
        chk(cpu_res_drive == e.rs, e.tag, "cpu_res_drive", int'(cpu_res_drive), int'(e.rs));
        chk(load_mode == e.lm, e.tag, "load_mode", int'(load_mode), int'(e.lm));
        chk(free_clk_en == e.fr, e.tag, "free_clk_en", int'(free_clk_en), int'(e.fr));
        chk(busy == e.by, e.tag, "busy", int'(busy), int'(e.by));
        chk(done == e.dn, e.tag, "done", int'(done), int'(e.dn));
        chk(buf_load == e.ld, "R6", "buf_load", int'(buf_load), int'(e.ld));
        if (e.ld) chk(buf_data == e.bd, e.btag, "buf_data", int'(buf_data), int'(e.bd));
    endtask

    // Start a load and compare every cycle; optionally pulse start mid-run.
    task automatic run_load(input logic [15:0] a0, input int poke_at);
        int cyc;
        @(negedge clk);
        start = 1'b1;
        start_addr = a0;
        build(a0);
        cyc = 0;
        while (q.size() > 0) begin
            exp_t e;
            @(negedge clk);
            start = 1'b0;
            if (cyc == poke_at) begin
                start = 1'b1;        // R2: must be ignored while busy
                start_addr = 16'h1234;
            end
            e = q.pop_front();
            compare_one(e);
            cyc++;
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cpu_clk == 1'b0, "R1", "cpu_clk", int'(cpu_clk), 0);
        chk(cpu_res_drive == 1'b0, "R1", "cpu_res_drive", int'(cpu_res_drive), 0);
        chk(load_mode == 1'b0, "R1", "load_mode", int'(load_mode), 0);
        chk(free_clk_en == 1'b1, "R1", "free_clk_en", int'(free_clk_en), 1);
        chk(busy == 1'b0 && done == 1'b0 && buf_load == 1'b0, "R1", "busy/done/buf_load",
            int'({busy, done, buf_load}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // Crosses the bank threshold page, with a start poke mid-run.
        run_load(16'hFEFE, 300);
        // Single-byte load: start address already at the last address.
        run_load(16'hFFFF, 5);
        // Short load without a poke.
        run_load(16'hFFFC, -1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule